// File: doc/BRIEF.md
# EEPROM Write-Protection Status Register

This block holds the protection state of a small serial EEPROM and rules on every write request that reaches the array or the status register. It keeps a write-enable latch, a two-bit block-protect level and a sticky lock-enable bit. It also watches an active-low hardware protect pin. When the lock-enable bit is 1 and the pin is low, the status register refuses every change, including the change that would clear the lock.

A command decoder sends one-cycle strobes to the block: set or clear the write-enable latch, a status write carrying a new byte, or a memory write carrying a byte address. One cycle after each request the block gives a one-cycle grant or deny. A grant marks the block busy. The programming timer ends the busy period with a done strobe, and that strobe also clears the write-enable latch. The status byte is always visible for status reads.

Top module: `wprot_status`

## Requirements
- R1: After reset the status byte reads 0x00 and `grant_o` and `deny_o` are both low.
- R2: Block-protect level 0 protects no address, level 1 protects the top quarter (0xC00–0xFFF for the default 4 KB array), level 2 protects the top half (0x800–0xFFF), and level 3 protects the whole array.
- R3: Hardware lock is active only while `wp_n_i` is low and the lock-enable bit is 1. When the write-enable latch is 1 and the block is idle, a status write is granted whenever the hardware lock is not active.
- R4: While the hardware lock is active, every status write is denied and the status byte does not change. In particular, a lock-enable bit of 1 stays 1 for as long as `wp_n_i` stays low.
- R5: A memory write to a protected address is denied, whatever the state of the latch, the lock-enable bit and the pin.
- R6: While the write-enable latch is 0, every memory write and every status write is denied.
- R7: With the latch at 1 and the block idle, a memory write to an unprotected address is granted.
- R8: A granted status write loads `sr_data_i[3:2]` into the block-protect level and `sr_data_i[7]` into the lock-enable bit, at the same clock edge that raises the grant. All other data bits are ignored.
- R9: A grant sets busy. A `prog_done_i` pulse while busy clears both busy and the write-enable latch. A `prog_done_i` pulse while idle has no effect.
- R10: While busy, every write request is denied and the latch set and clear strobes are ignored.
- R11: The status byte layout is bit0 = busy, bit1 = write-enable latch, bits 3:2 = block-protect level, bit7 = lock-enable, and bits 6:4 read 0.
- R12: Each request produces exactly one one-cycle pulse, on `grant_o` or on `deny_o`, in the cycle after the request. When a status write and a memory write arrive in the same cycle, only the status write is considered, and the memory write gets no grant.
- R13: Outside busy, `wel_set_i` sets the write-enable latch and `wel_clr_i` clears it. Clear wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n_i | input | 1 | Hardware protect pin, active low |
| wel_set_i | input | 1 | Strobe: set the write-enable latch |
| wel_clr_i | input | 1 | Strobe: clear the write-enable latch |
| sr_wr_i | input | 1 | Strobe: status write request |
| sr_data_i | input | 8 | New status byte for a status write |
| mem_wr_i | input | 1 | Strobe: memory write request |
| mem_addr_i | input | ADDR_W | Byte address of the memory write |
| prog_done_i | input | 1 | Strobe from the programming timer: write finished |
| grant_o | output | 1 | One-cycle pulse: last request granted |
| deny_o | output | 1 | One-cycle pulse: last request denied |
| status_o | output | 8 | Current status byte |

## Verification
On every cycle the assertions check the following: grant and deny are never high together; no grant follows a cycle spent busy, or a cycle in which the latch was 0; the lock-enable bit cannot fall while the hardware lock holds; no memory write that hits the protected region is granted; and a done strobe while busy leaves the latch and busy both cleared. Other behaviour can only be shown by the bench's scenarios. These are the exact region boundaries for each protect level, the values a granted status write loads, the status byte layout, the priority between simultaneous requests, and the ignored strobes while busy. The bench sweeps every combination of protect level, lock-enable, pin and latch over a grid of addresses that includes the region edges.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int STAT_W    = 8;
  localparam int BUSY_BIT  = 0;
  localparam int WEL_BIT   = 1;
  localparam int BP_LO_BIT = 2;
  localparam int LOCK_BIT  = 7;

  typedef logic [1:0] bp_level_t;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic busy, input logic wel, input bp_level_t bp, input logic lock_en);
    logic [STAT_W-1:0] s;
    s = '0;
    s[BUSY_BIT]             = busy;
    s[WEL_BIT]              = wel;
    s[BP_LO_BIT +: 2]       = bp;
    s[LOCK_BIT]             = lock_en;
    return s;
  endfunction
endpackage

// File: rtl/wprot_region.sv
module wprot_region
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  bp_level_t         bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int TOP = ADDR_W - 1;

  generate
    if (ADDR_W >= 2) begin : g_wide
      always_comb begin
        unique case (bp_i)
          2'd0:    hit_o = 1'b0;
          2'd1:    hit_o = &addr_i[TOP -: 2];
          2'd2:    hit_o = addr_i[TOP];
          default: hit_o = 1'b1;
        endcase
      end
    end else begin : g_narrow
      assign hit_o = (bp_i == 2'd3) || ((bp_i == 2'd2) && addr_i[TOP]);
    end
  endgenerate
endmodule

// File: rtl/wprot_decide.sv
module wprot_decide (
  input  logic wel_i,
  input  logic busy_i,
  input  logic hw_lock_i,
  input  logic hit_i,
  input  logic sr_req_i,
  input  logic mem_req_i,
  output logic sr_ok_o,
  output logic mem_ok_o,
  output logic any_req_o
);
  logic open_w;
  assign open_w    = wel_i & ~busy_i;
  assign sr_ok_o   = sr_req_i & open_w & ~hw_lock_i;
  assign mem_ok_o  = mem_req_i & ~sr_req_i & open_w & ~hit_i;
  assign any_req_o = sr_req_i | mem_req_i;
endmodule

// File: rtl/wprot_status.sv
module wprot_status
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              mem_wr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              prog_done_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic [7:0]        status_o
);
  logic      wel_q, busy_q, lock_q, grant_q, deny_q;
  bp_level_t bp_q;

  // named internal events
  logic hw_lock_w, hit_w, sr_ok_w, mem_ok_w, any_req_w, grant_d, done_ev_w;

  assign hw_lock_w = lock_q & ~wp_n_i;
  assign done_ev_w = busy_q & prog_done_i;

  wprot_region #(.ADDR_W(ADDR_W)) u_region (
    .bp_i(bp_q), .addr_i(mem_addr_i), .hit_o(hit_w));

  wprot_decide u_decide (
    .wel_i(wel_q), .busy_i(busy_q), .hw_lock_i(hw_lock_w), .hit_i(hit_w),
    .sr_req_i(sr_wr_i), .mem_req_i(mem_wr_i),
    .sr_ok_o(sr_ok_w), .mem_ok_o(mem_ok_w), .any_req_o(any_req_w));

  assign grant_d = sr_ok_w | mem_ok_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      busy_q  <= 1'b0;
      lock_q  <= 1'b0;
      bp_q    <= '0;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      deny_q  <= any_req_w & ~grant_d;
      if (done_ev_w)                 wel_q <= 1'b0;
      else if (!busy_q && wel_clr_i) wel_q <= 1'b0;
      else if (!busy_q && wel_set_i) wel_q <= 1'b1;
      if (grant_d)        busy_q <= 1'b1;
      else if (done_ev_w) busy_q <= 1'b0;
      if (sr_ok_w) begin
        bp_q   <= sr_data_i[3:2];
        lock_q <= sr_data_i[7];
      end
    end
  end

  assign grant_o  = grant_q;
  assign deny_o   = deny_q;
  assign status_o = pack_status(busy_q, wel_q, bp_q, lock_q);

  // R12
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_o, deny_o}));
  // R6
  wel_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_q |=> !grant_o);
  // R10
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !grant_o);
  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_lock_w && !prog_done_i) ##1 !wp_n_i |-> lock_q);
  // R4
  lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && hw_lock_w) |=> !grant_o);
  // R5
  region_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_i && !sr_wr_i && hit_w) |=> !grant_o);
  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev_w |=> (!wel_q && !busy_q));
endmodule

// File: tb/wprot_status_bench.sv
`timescale 1ns/1ps
module wprot_status_bench;
  localparam int ADDR_W = 12;
  localparam int SIZE   = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wp_n = 1'b1, wset = 1'b0, wclr = 1'b0, srw = 1'b0, memw = 1'b0, pdone = 1'b0;
  logic [7:0] sdata = '0;
  logic [ADDR_W-1:0] maddr = '0;
  logic grant, deny;
  logic [7:0] status;

  int checks = 0, fails = 0;
  bit m_wel = 0, m_busy = 0, m_lock = 0;
  int m_bp = 0;

  always #2.5 clk = ~clk;

  wprot_status #(.ADDR_W(ADDR_W)) u_wprot_status (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .wel_set_i(wset), .wel_clr_i(wclr),
    .sr_wr_i(srw), .sr_data_i(sdata), .mem_wr_i(memw), .mem_addr_i(maddr),
    .prog_done_i(pdone), .grant_o(grant), .deny_o(deny), .status_o(status));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_hit(input int bp, input int a);
    int lim;
    case (bp)
      0: lim = SIZE;
      1: lim = SIZE - SIZE / 4;
      2: lim = SIZE / 2;
      default: lim = 0;
    endcase
    return a >= lim;
  endfunction

  function automatic int m_stat();
    return (int'(m_lock) << 7) | (m_bp << 2) | (int'(m_wel) << 1) | int'(m_busy);
  endfunction

  task automatic pulse();
    @(negedge clk);
    wset = 0; wclr = 0; srw = 0; memw = 0; pdone = 0;
  endtask

  task automatic check_stat(input string tag);
    chk(status == 8'(m_stat()), tag, status, m_stat());
  endtask

  task automatic wel_op(input bit s, input bit c);
    wset = s; wclr = c; pulse();
    if (!m_busy) begin
      if (c) m_wel = 0; else if (s) m_wel = 1;
    end
    check_stat(m_busy ? "R10" : "R13");
  endtask

  task automatic done_op();
    pdone = 1; pulse();
    if (m_busy) begin m_busy = 0; m_wel = 0; end
    check_stat("R9");
  endtask

  task automatic mem_op(input int a);
    bit exp; string tag;
    exp = m_wel && !m_busy && !m_hit(m_bp, a);
    tag = m_busy ? "R10" : (!m_wel ? "R6" : (m_hit(m_bp, a) ? "R5" : "R7"));
    memw = 1; maddr = ADDR_W'(a); pulse();
    chk(grant == exp && deny == !exp, tag, {grant, deny}, {exp, !exp});
    if (exp) m_busy = 1;
    check_stat("R11");
  endtask

  task automatic sr_op(input logic [7:0] d, input bit with_mem);
    bit lock, exp; string tag;
    lock = m_lock && !wp_n;
    exp  = m_wel && !m_busy && !lock;
    tag  = m_busy ? "R10" : (!m_wel ? "R6" : (lock ? "R4" : "R3"));
    srw = 1; sdata = d; memw = with_mem; maddr = '0; pulse();
    chk(grant == exp && deny == !exp, with_mem ? "R12" : tag, {grant, deny}, {exp, !exp});
    if (exp) begin m_bp = d[3:2]; m_lock = d[7]; m_busy = 1; end
    check_stat("R8");
  endtask

  task automatic setup_state(input int bp, input bit lk);
    wp_n = 1;
    if (m_busy) done_op();
    wel_op(1, 0);
    sr_op(8'((int'(lk) << 7) | (bp << 2)), 0);
    done_op();
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "WATCHDOG", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int edges[6] = '{0, SIZE/2 - 1, SIZE/2, SIZE - SIZE/4 - 1, SIZE - SIZE/4, SIZE - 1};
    repeat (3) @(negedge clk);
    chk(status == 8'h00 && !grant && !deny, "R1", {status, grant, deny}, 0);
    rst_n = 1;
    @(negedge clk);
    check_stat("R1");

    // full sweep: protect level x lock-enable x pin x latch (R2 boundaries)
    for (int bp = 0; bp < 4; bp++)
      for (int lk = 0; lk < 2; lk++)
        for (int pin = 0; pin < 2; pin++)
          for (int w = 0; w < 2; w++) begin
            setup_state(bp, lk[0]);
            wp_n = pin[0];
            if (w != 0) wel_op(1, 0);
            for (int a = 0; a < SIZE + 6 * 64; a += 64) begin
              int aa;
              aa = (a < SIZE) ? a : edges[(a - SIZE) / 64];
              mem_op(aa);
              if (m_busy) done_op();
              if (w != 0 && !m_wel) wel_op(1, 0);
            end
            sr_op(8'(((1 - lk) << 7) | 8'h70 | ((3 - bp) << 2) | 3), 0);
            if (m_busy) done_op();
          end

    // lock stays set while pin low; released by raising pin (R4, R3)
    setup_state(1, 1);
    wp_n = 0;
    wel_op(1, 0);
    sr_op(8'h00, 0);
    chk(status[7] == 1'b1, "R4", status[7], 1);
    wp_n = 1;
    sr_op(8'h00, 0);
    done_op();
    chk(status == 8'h00, "R3", status, 0);

    // busy window: strobes and requests ignored (R10)
    wel_op(1, 0);
    mem_op(5);
    wel_op(0, 1);
    mem_op(6);
    sr_op(8'h8c, 0);
    done_op();
    done_op();               // idle done: no effect (R9)

    // set and clear together: clear wins (R13)
    wel_op(1, 1);
    chk(status[1] == 1'b0, "R13", status[1], 0);

    // simultaneous requests: status write wins (R12)
    wel_op(1, 0);
    sr_op(8'h08, 1);
    done_op();
    chk(status == 8'h08, "R12", status, 8'h08);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule